// File: doc/BRIEF.md
# Byte-Serial Reflected CRC-32 Engine

This block keeps a running 32-bit CRC remainder and folds one data byte into it each time the byte strobe is taken. It works in the reflected, LSB-first form of the 0x04C11DB7 generator polynomial. The remainder register shifts right, and the feedback uses the bit-reversed constant 0xEDB88320. The output shows the remainder register as it stands, and no final inversion is applied to it.

Before a message, an initialise strobe reloads the remainder. A select input chooses the reload value: all-zeros or all-ones. A compile-time parameter sets how a byte is processed. In the single-cycle variant the whole byte is folded in at one clock edge. In the serial variant the byte is XORed in when it is accepted, and the engine then makes one shift step per clock over the following eight cycles. Throughout those eight cycles the ready output is low.

Top module: `crc32r_engine`

## Requirements
- R1: While the synchronous reset is high, the remainder is set to 0xFFFFFFFF and ready is set to 1.
- R2: When an initialise request is taken with no byte, the result on the next cycle is 0xFFFFFFFF if `init_ones`=1 and 0x00000000 if `init_ones`=0.
- R3: A taken byte first XORs into bits 7:0 of the remainder. The remainder then goes through eight steps. In each step, an LSB of 1 gives a right shift followed by an XOR with 0xEDB88320, and an LSB of 0 gives a right shift alone.
- R4: From the all-ones preset, the single byte 0x63 gives the result 0xF9462090.
- R5: The result output is the raw remainder. For example, the all-zeros preset followed by byte 0x00 reads 0x00000000.
- R6: If an initialise request and a byte are taken in the same cycle, the initialise request wins. The byte is then folded in starting from the newly selected preset.
- R7: With SERIAL=0, ready stays at 1, and the updated result appears on the cycle after the byte is taken.
- R8: With SERIAL=1, ready is 0 for exactly the eight cycles after a byte is taken. The final result for that byte is present when ready returns to 1.
- R9: With SERIAL=1, a byte offered while ready is 0 is ignored.
- R10: With SERIAL=1, an initialise request made while ready is 0 is ignored.
- R11: While ready is 1 and neither a byte nor an initialise request is offered, the result holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_req | input | 1 | Initialise the remainder to the selected preset |
| init_ones | input | 1 | Preset select: 1 selects all-ones, 0 selects all-zeros |
| din | input | 8 | Data byte |
| din_vld | input | 1 | Data byte qualifier |
| crc_out | output | 32 | Raw remainder register |
| ready | output | 1 | Engine can take a byte or initialise request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the preset reload and the byte fold. The bench provokes it by raising the initialise request together with a valid byte while the engine is idle, using a preset different from the remainder in use. The result must equal the software bit-loop model run from the new preset, not from the old remainder. The second pair is a running shift and new input: in the serial variant, a byte and an initialise request are offered during the busy window. The result that appears when ready returns must be the one for the original byte alone, and the busy window must still last eight cycles.

// File: rtl/crc32r_pkg.sv
package crc32r_pkg;
  localparam int CRC_W  = 32;
  localparam int DATA_W = 8;
  localparam logic [CRC_W-1:0] POLY_REFL = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] PRESET_ONES = {CRC_W{1'b1}};
  localparam logic [CRC_W-1:0] PRESET_ZERO = {CRC_W{1'b0}};

  // one reflected shift step of the remainder
  function automatic logic [CRC_W-1:0] crc32r_bit_step(input logic [CRC_W-1:0] r);
    logic [CRC_W-1:0] s;
    s = r >> 1;
    if (r[0]) s = s ^ POLY_REFL;
    return s;
  endfunction

  // fold one whole byte into the remainder
  function automatic logic [CRC_W-1:0] crc32r_byte_step(input logic [CRC_W-1:0] r,
                                                        input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] t;
    t = r ^ {{(CRC_W-DATA_W){1'b0}}, d};
    for (int i = 0; i < DATA_W; i++) t = crc32r_bit_step(t);
    return t;
  endfunction

  function automatic logic [CRC_W-1:0] crc32r_preset(input logic ones);
    return ones ? PRESET_ONES : PRESET_ZERO;
  endfunction
endpackage

// File: rtl/crc32r_preset.sv
module crc32r_preset
  import crc32r_pkg::*;
(
  input  logic             init_ones,
  input  logic             init_take,
  input  logic [CRC_W-1:0] rem,
  output logic [CRC_W-1:0] preset,
  output logic [CRC_W-1:0] base
);
  always_comb begin
    preset = crc32r_preset(init_ones);
    base   = init_take ? preset : rem;
  end
endmodule

// File: rtl/crc32r_seq.sv
module crc32r_seq
  import crc32r_pkg::*;
#(
  parameter bit SERIAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  output logic ready,
  output logic step_en
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  generate
    if (SERIAL) begin : g_serial
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst)                    cnt_q <= '0;
        else if (accept)            cnt_q <= CNT_W'(DATA_W);
        else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
      end
      assign ready   = (cnt_q == '0);
      assign step_en = (cnt_q != '0);
    end else begin : g_fast
      logic unused_acc;
      assign unused_acc = accept ^ clk ^ rst;
      assign ready   = 1'b1;
      assign step_en = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/crc32r_next.sv
module crc32r_next
  import crc32r_pkg::*;
#(
  parameter bit SERIAL = 1'b1
) (
  input  logic [CRC_W-1:0]  rem,
  input  logic [CRC_W-1:0]  base,
  input  logic [CRC_W-1:0]  preset,
  input  logic [DATA_W-1:0] din,
  input  logic              accept,
  input  logic              init_take,
  input  logic              step_en,
  output logic [CRC_W-1:0]  nxt
);
  logic [CRC_W-1:0] step_val;
  logic [CRC_W-1:0] idle_val;

  always_comb begin
    step_val = crc32r_bit_step(rem);
    idle_val = step_en ? step_val : (init_take ? preset : rem);
  end

  generate
    if (SERIAL) begin : g_serial
      // load the XORed byte, then one shift step per busy cycle
      always_comb nxt = accept ? (base ^ {{(CRC_W-DATA_W){1'b0}}, din}) : idle_val;
    end else begin : g_fast
      always_comb nxt = accept ? crc32r_byte_step(base, din) : idle_val;
    end
  endgenerate
endmodule

// File: rtl/crc32r_engine.sv
module crc32r_engine
  import crc32r_pkg::*;
#(
  parameter bit SERIAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_req,
  input  logic              init_ones,
  input  logic [DATA_W-1:0] din,
  input  logic              din_vld,
  output logic [CRC_W-1:0]  crc_out,
  output logic              ready
);
  logic [CRC_W-1:0] rem_q;
  logic [CRC_W-1:0] preset_w;
  logic [CRC_W-1:0] base_w;
  logic [CRC_W-1:0] nxt_w;
  logic             accept_w;
  logic             init_take_w;
  logic             step_en_w;

  assign accept_w    = din_vld & ready;
  assign init_take_w = init_req & ready;

  crc32r_preset u_preset (
    .init_ones (init_ones),
    .init_take (init_take_w),
    .rem       (rem_q),
    .preset    (preset_w),
    .base      (base_w)
  );

  crc32r_seq #(.SERIAL(SERIAL)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept_w),
    .ready   (ready),
    .step_en (step_en_w)
  );

  crc32r_next #(.SERIAL(SERIAL)) u_next (
    .rem       (rem_q),
    .base      (base_w),
    .preset    (preset_w),
    .din       (din),
    .accept    (accept_w),
    .init_take (init_take_w),
    .step_en   (step_en_w),
    .nxt       (nxt_w)
  );

  always_ff @(posedge clk) begin
    if (rst) rem_q <= PRESET_ONES;
    else     rem_q <= nxt_w;
  end

  assign crc_out = rem_q;
endmodule

// File: rtl/crc32r_engine_chk.sv
module crc32r_engine_chk
  import crc32r_pkg::*;
#(
  parameter bit SERIAL = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              init_req,
  input logic              init_ones,
  input logic [DATA_W-1:0] din,
  input logic              din_vld,
  input logic [CRC_W-1:0]  crc_out,
  input logic              ready,
  input logic              accept,
  input logic              init_take
);
  logic [7:0] low_cnt;
  always_ff @(posedge clk) begin
    if (rst)         low_cnt <= '0;
    else if (!ready) low_cnt <= low_cnt + 1'b1;
    else             low_cnt <= '0;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (crc_out == PRESET_ONES && ready));

  p_init_r2: assert property (@(posedge clk) disable iff (rst)
    (init_take && !din_vld) |=> crc_out == crc32r_preset($past(init_ones)));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (ready && !din_vld && !init_req) |=> $stable(crc_out));

  generate
    if (SERIAL) begin : g_serial
      p_busy_r8: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);
      p_window_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> low_cnt == 8'(DATA_W));
      // R9 and R10: offered byte or init while busy leaves the shift step alone
      p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (!ready && (din_vld || init_req)) |=> crc_out == crc32r_bit_step($past(crc_out)));
    end else begin : g_fast
      p_ready_r7: assert property (@(posedge clk) disable iff (rst)
        din_vld |-> ready);
      // R3 and R6: one-cycle fold from the preset or from the old remainder
      p_fold_r6: assert property (@(posedge clk) disable iff (rst)
        accept |=> crc_out == crc32r_byte_step(
          $past(init_take) ? crc32r_preset($past(init_ones)) : $past(crc_out), $past(din)));
    end
  endgenerate
endmodule

bind crc32r_engine crc32r_engine_chk #(.SERIAL(SERIAL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .init_req  (init_req),
  .init_ones (init_ones),
  .din       (din),
  .din_vld   (din_vld),
  .crc_out   (crc_out),
  .ready     (ready),
  .accept    (accept_w),
  .init_take (init_take_w)
);

// File: tb/crc32r_engine_test.sv
`timescale 1ns/1ps
module crc32r_engine_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_ones = 1'b1;
  logic [7:0] din = '0;
  logic s_vld = 1'b0, s_init = 1'b0, f_vld = 1'b0, f_init = 1'b0;
  logic [31:0] s_crc, f_crc;
  logic s_rdy, f_rdy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] ms, mf;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  crc32r_engine #(.SERIAL(1'b1)) uut (
    .clk(clk), .rst(rst), .init_req(s_init), .init_ones(init_ones),
    .din(din), .din_vld(s_vld), .crc_out(s_crc), .ready(s_rdy));

  crc32r_engine #(.SERIAL(1'b0)) uut_fast (
    .clk(clk), .rst(rst), .init_req(f_init), .init_ones(init_ones),
    .din(din), .din_vld(f_vld), .crc_out(f_crc), .ready(f_rdy));

  // reference: feedback bit formed from remainder LSB and data bit together
  function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [7:0] b);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ b[i];
      c  = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  function automatic logic [31:0] pre(input logic ones);
    return ones ? 32'hFFFFFFFF : 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: serial results are popped when ready returns
  int  low_n = 0;
  bit  prev_rdy = 1'b1;
  always @(negedge clk) begin
    if (rst) begin
      low_n = 0; prev_rdy = 1'b1;
    end else begin
      if (!s_rdy) low_n++;
      if (s_rdy && !prev_rdy) begin
        check("R8 busy window length", 32'(low_n), 32'd8);
        if (exp_q.size() == 0) check("R8 unexpected result", s_crc, 32'hx);
        else check({tag_q.pop_front(), " serial result"}, s_crc, exp_q.pop_front());
        low_n = 0;
      end
      prev_rdy = s_rdy;
    end
  end

  task automatic wait_idle();
    while (!s_rdy) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !s_rdy) @(negedge clk);
  endtask

  task automatic do_init(input logic ones);
    wait_idle();
    s_init = 1'b1; f_init = 1'b1; init_ones = ones;
    @(negedge clk);
    s_init = 1'b0; f_init = 1'b0;
    ms = pre(ones); mf = pre(ones);
    check("R2 preset serial", s_crc, ms);
    check("R2 preset fast", f_crc, mf);
  endtask

  task automatic send(input logic [7:0] b, input logic ini, input logic ones, input logic poke);
    wait_idle();
    din = b; s_vld = 1'b1; f_vld = 1'b1; s_init = ini; f_init = ini; init_ones = ones;
    ms = ref_byte(ini ? pre(ones) : ms, b);
    mf = ref_byte(ini ? pre(ones) : mf, b);
    exp_q.push_back(ms);
    tag_q.push_back(poke ? "R9 R10" : (ini ? "R6" : "R3"));
    @(negedge clk);
    s_vld = 1'b0; f_vld = 1'b0; s_init = 1'b0; f_init = 1'b0;
    check(ini ? "R6 fast result" : "R7 fast result", f_crc, mf);
    check("R7 fast ready", 32'(f_rdy), 32'd1);
    if (poke) begin
      din = ~b; s_vld = 1'b1; s_init = 1'b1; init_ones = ~ones;
      @(negedge clk);
      s_vld = 1'b0; s_init = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset crc serial", s_crc, 32'hFFFFFFFF);
    check("R1 reset ready serial", 32'(s_rdy), 32'd1);
    check("R1 reset crc fast", f_crc, 32'hFFFFFFFF);
    rst = 1'b0;
    ms = 32'hFFFFFFFF; mf = 32'hFFFFFFFF;

    do_init(1'b1);
    send(8'h63, 1'b0, 1'b1, 1'b0);
    drain();
    check("R4 known vector serial", s_crc, 32'hF9462090);
    check("R4 known vector fast", f_crc, 32'hF9462090);

    do_init(1'b0);
    send(8'h00, 1'b0, 1'b0, 1'b0);
    drain();
    check("R5 raw zero serial", s_crc, 32'h0);
    check("R5 raw zero fast", f_crc, 32'h0);

    do_init(1'b1);
    send(8'hAA, 1'b0, 1'b1, 1'b0);
    send(8'hBB, 1'b0, 1'b1, 1'b0);
    send(8'hCC, 1'b0, 1'b1, 1'b0);
    // init with byte in same cycle, preset differs from running remainder
    send(8'h5C, 1'b1, 1'b0, 1'b0);
    send(8'h3E, 1'b1, 1'b1, 1'b0);
    // byte and init offered during the busy window
    send(8'hA5, 1'b0, 1'b0, 1'b1);
    drain();

    repeat (4) @(negedge clk);
    check("R11 hold serial", s_crc, ms);
    check("R11 hold fast", f_crc, mf);

    for (int k = 0; k < 40; k++) begin
      send(8'($urandom), ($urandom % 8) == 0, 1'($urandom), ($urandom % 4) == 0);
    end
    drain();
    check("R3 final serial", s_crc, ms);
    check("R3 final fast", f_crc, mf);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule